// File: doc/BRIEF.md
# Register-Driven Two-Input Bitwise Lookup Unit

This execution unit evaluates an arbitrary two-input Boolean function across every bit lane of a 64-bit word. The function is not fixed in the instruction. It is a four-entry truth table read at run time from a third source register. One instruction bit picks which of the two lowest nibbles of that register is used as the table. For each lane, the bit of the first source and the bit of the second source form an index into the table, and the addressed table bit becomes that lane's result bit.

The unit decodes the source and destination register numbers from the instruction word, so a register file can supply the three operands in the same cycle. It delivers the result one clock later together with a valid strobe, the destination number and a write enable. The write enable drops when the opcode fields do not match the unit's configured opcodes.

Two such operations, one per nibble, can be merged by a separate immediate-driven three-input unit. Software uses this pairing to evaluate a three-input function whose eight-entry table sits in a register. The bench exercises this pairing.

Top module: `dbl_lut_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` and `res_wen` are 0 and `res_data` is all zeros.
- R2: In the same cycle as the instruction is presented, `src_ra_idx`, `src_rb_idx` and `src_rc_idx` equal instruction bits [20:16], [15:11] and [10:6] (bit 0 = least significant).
- R3: When the half-select bit, instruction bit [5], is 0, the table is `opnd_rc[3:0]`.
- R4: When the half-select bit is 1, the table is `opnd_rc[7:4]`. Bits [63:8] of `opnd_rc` never affect the result.
- R5: For each lane i, the index k is {`opnd_ra[i]`, `opnd_rb[i]`}, with the first-source bit as the more significant bit. Result bit i equals table bit k, with table bit 0 the least significant.
- R6: The result appears on the clock edge after an issue. `res_valid` is high for exactly one cycle per issue. `res_data` and `res_dest` hold while no issue occurs.
- R7: `res_dest` equals instruction bits [25:21] of the issue that produced the result.
- R8: `res_wen` is 1 only when the issue's bits [31:26] equal `PRIM_OPC` and bits [4:0] equal `EXT_OPC`. On a mismatch `res_valid` is still 1 and `res_wen` is 0.
- R9: Issues on consecutive cycles produce results on consecutive cycles, each with its own data, destination and write enable.
- R10: Two operations on the same sources and table register, one per half, merged lane-wise by a three-input lookup with immediate 0xD8 on a selector word, equal an eight-entry lookup. In that lookup the selector bit is the index MSB and the table is the register's low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction and its operands are presented this cycle |
| issue_instr | input | 32 | Instruction word |
| src_ra_idx | output | 5 | First source register number |
| src_rb_idx | output | 5 | Second source register number |
| src_rc_idx | output | 5 | Table register number |
| opnd_ra | input | XLEN | First source value |
| opnd_rb | input | XLEN | Second source value |
| opnd_rc | input | XLEN | Table register value |
| res_valid | output | 1 | Result strobe, one cycle per issue |
| res_wen | output | 1 | Register write enable for the result |
| res_dest | output | 5 | Destination register number |
| res_data | output | XLEN | Lookup result |

## Verification
Two functions of the unit can fall in the same cycle. One is presenting a finished result with its write enable. The other is capturing the next issue, which may carry the other half-select or a mismatching opcode. The bench provokes this by issuing back to back. It first issues a matching operation, then a mismatching one on the next cycle, with different tables and destinations. Each cycle's `res_data`, `res_dest` and `res_wen` must belong to its own issue, with no carry-over from the neighbour.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
   localparam int INSTR_W   = 32;
   localparam int REG_IDX_W = 5;
   localparam int PRIM_W    = 6;
   localparam int EXT_W     = 5;
   localparam int IDX_BITS  = 2;
   localparam int TBL_W     = 1 << IDX_BITS;
   localparam int N_HALVES  = 2;

   // Fields listed from instruction bit 31 down to bit 0.
   typedef struct packed {
      logic [PRIM_W-1:0]    prim;
      logic [REG_IDX_W-1:0] rt;
      logic [REG_IDX_W-1:0] ra;
      logic [REG_IDX_W-1:0] rb;
      logic [REG_IDX_W-1:0] rc;
      logic                 half;
      logic [EXT_W-1:0]     ext;
   } dbl_fields_t;
endpackage

// File: rtl/dbl_decode.sv
module dbl_decode
   import dbl_pkg::*;
#(
   parameter logic [PRIM_W-1:0] PRIM_OPC = 6'd22,
   parameter logic [EXT_W-1:0]  EXT_OPC  = 5'd11
) (
   input  logic [INSTR_W-1:0] instr,
   output dbl_fields_t        fields,
   output logic               op_match
);
   generate
      if ($bits(dbl_fields_t) != INSTR_W) begin : g_bad_layout
         $error("dbl_decode: field layout does not fill the instruction word");
      end
   endgenerate

   logic prim_hit;
   logic ext_hit;

   always_comb begin
      fields   = dbl_fields_t'(instr);
      prim_hit = (fields.prim == PRIM_OPC);
      ext_hit  = (fields.ext == EXT_OPC);
      op_match = prim_hit & ext_hit;
   end
endmodule

// File: rtl/dbl_table_pick.sv
module dbl_table_pick
   import dbl_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]  tbl_src,
   input  logic             half_sel,
   output logic [TBL_W-1:0] table_out
);
   localparam int SPAN_W = N_HALVES * TBL_W;
   localparam int SHW    = $clog2(SPAN_W);

   generate
      if (XLEN < SPAN_W) begin : g_bad_width
         $error("dbl_table_pick: register narrower than both table halves");
      end
   endgenerate

   logic [SHW-1:0]  shamt;
   logic [XLEN-1:0] shifted;

   always_comb begin
      shamt     = half_sel ? SHW'(TBL_W) : '0;
      shifted   = tbl_src >> shamt;
      table_out = shifted[TBL_W-1:0];
   end
endmodule

// File: rtl/dbl_lane_array.sv
module dbl_lane_array
   import dbl_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int LANE_IMPL = 0   // 0: indexed select, 1: sum of products
) (
   input  logic [XLEN-1:0]  in_a,
   input  logic [XLEN-1:0]  in_b,
   input  logic [TBL_W-1:0] table_in,
   output logic [XLEN-1:0]  lanes_out
);
   generate
      if (LANE_IMPL != 0 && LANE_IMPL != 1) begin : g_bad_impl
         $error("dbl_lane_array: LANE_IMPL must be 0 or 1");
      end
      if (IDX_BITS != 2) begin : g_bad_idx
         $error("dbl_lane_array: lane logic is built for two inputs");
      end

      for (genvar i = 0; i < XLEN; i++) begin : g_lane
         if (LANE_IMPL == 0) begin : g_idx
            logic [IDX_BITS-1:0] k;
            always_comb begin
               k            = {in_a[i], in_b[i]};
               lanes_out[i] = table_in[k];
            end
         end else begin : g_sop
            always_comb begin
               lanes_out[i] = (~in_a[i] & ~in_b[i] & table_in[0])
                            | (~in_a[i] &  in_b[i] & table_in[1])
                            | ( in_a[i] & ~in_b[i] & table_in[2])
                            | ( in_a[i] &  in_b[i] & table_in[3]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dbl_lut_unit.sv
module dbl_lut_unit
   import dbl_pkg::*;
#(
   parameter int                XLEN      = 64,
   parameter int                LANE_IMPL = 0,
   parameter logic [PRIM_W-1:0] PRIM_OPC  = 6'd22,
   parameter logic [EXT_W-1:0]  EXT_OPC   = 5'd11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 issue_valid,
   input  logic [INSTR_W-1:0]   issue_instr,
   output logic [REG_IDX_W-1:0] src_ra_idx,
   output logic [REG_IDX_W-1:0] src_rb_idx,
   output logic [REG_IDX_W-1:0] src_rc_idx,
   input  logic [XLEN-1:0]      opnd_ra,
   input  logic [XLEN-1:0]      opnd_rb,
   input  logic [XLEN-1:0]      opnd_rc,
   output logic                 res_valid,
   output logic                 res_wen,
   output logic [REG_IDX_W-1:0] res_dest,
   output logic [XLEN-1:0]      res_data
);
   generate
      if (XLEN < 1) begin : g_bad_xlen
         $error("dbl_lut_unit: XLEN must be positive");
      end
   endgenerate

   dbl_fields_t      fld;
   logic             op_match;
   logic [TBL_W-1:0] tbl;
   logic [XLEN-1:0]  lane_res;

   dbl_decode #(
      .PRIM_OPC (PRIM_OPC),
      .EXT_OPC  (EXT_OPC)
   ) u_decode (
      .instr    (issue_instr),
      .fields   (fld),
      .op_match (op_match)
   );

   assign src_ra_idx = fld.ra;
   assign src_rb_idx = fld.rb;
   assign src_rc_idx = fld.rc;

   dbl_table_pick #(
      .XLEN      (XLEN)
   ) u_pick (
      .tbl_src   (opnd_rc),
      .half_sel  (fld.half),
      .table_out (tbl)
   );

   dbl_lane_array #(
      .XLEN      (XLEN),
      .LANE_IMPL (LANE_IMPL)
   ) u_lanes (
      .in_a      (opnd_ra),
      .in_b      (opnd_rb),
      .table_in  (tbl),
      .lanes_out (lane_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_wen   <= 1'b0;
         res_dest  <= '0;
         res_data  <= '0;
      end else begin
         res_valid <= issue_valid;
         res_wen   <= issue_valid & op_match;
         if (issue_valid) begin
            res_dest <= fld.rt;
            res_data <= lane_res;
         end
      end
   end
endmodule

// File: rtl/dbl_lut_unit_chk.sv
module dbl_lut_unit_chk
   import dbl_pkg::*;
#(
   parameter int                XLEN     = 64,
   parameter logic [PRIM_W-1:0] PRIM_OPC = 6'd22,
   parameter logic [EXT_W-1:0]  EXT_OPC  = 5'd11
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 issue_valid,
   input logic [PRIM_W-1:0]    chk_prim,
   input logic [EXT_W-1:0]     chk_ext,
   input logic [REG_IDX_W-1:0] chk_rt,
   input logic                 chk_half,
   input logic [7:0]           chk_tbl_byte,
   input logic                 res_valid,
   input logic                 res_wen,
   input logic [REG_IDX_W-1:0] res_dest,
   input logic [XLEN-1:0]      res_data
);
   AST_VALID_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |=> res_valid); // R6
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> !res_valid); // R6
   AST_DATA_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> $stable(res_data) && $stable(res_dest)); // R6
   AST_WEN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      res_wen |-> res_valid); // R8
   AST_MISMATCH_NO_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && (chk_prim != PRIM_OPC || chk_ext != EXT_OPC) |=> !res_wen); // R8
   AST_DEST_FROM_RT: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |=> res_dest == $past(chk_rt)); // R7
   AST_LOW_TABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && !chk_half && chk_tbl_byte[3:0] == 4'h0 |=> res_data == '0); // R3
   AST_HIGH_TABLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && chk_half && chk_tbl_byte[7:4] == 4'hF |=> res_data == '1); // R4
endmodule

bind dbl_lut_unit dbl_lut_unit_chk #(
   .XLEN         (XLEN),
   .PRIM_OPC     (PRIM_OPC),
   .EXT_OPC      (EXT_OPC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .issue_valid  (issue_valid),
   .chk_prim     (issue_instr[31:26]),
   .chk_ext      (issue_instr[4:0]),
   .chk_rt       (issue_instr[25:21]),
   .chk_half     (issue_instr[5]),
   .chk_tbl_byte (opnd_rc[7:0]),
   .res_valid    (res_valid),
   .res_wen      (res_wen),
   .res_dest     (res_dest),
   .res_data     (res_data)
);

// File: tb/dbl_lut_unit_tb.sv
module dbl_lut_unit_tb;
   localparam int XLEN = 64;
   localparam logic [5:0] PO = 6'd22;
   localparam logic [4:0] XO = 5'd11;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            issue_valid = 1'b0;
   logic [31:0]     issue_instr = '0;
   logic [4:0]      src_ra_idx, src_rb_idx, src_rc_idx;
   logic [XLEN-1:0] opnd_ra = '0, opnd_rb = '0, opnd_rc = '0;
   logic            res_valid, res_wen;
   logic [4:0]      res_dest;
   logic [XLEN-1:0] res_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   dbl_lut_unit #(.XLEN(XLEN), .PRIM_OPC(PO), .EXT_OPC(XO)) u_dut (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_instr(issue_instr),
      .src_ra_idx(src_ra_idx), .src_rb_idx(src_rb_idx), .src_rc_idx(src_rc_idx),
      .opnd_ra(opnd_ra), .opnd_rb(opnd_rb), .opnd_rc(opnd_rc),
      .res_valid(res_valid), .res_wen(res_wen), .res_dest(res_dest), .res_data(res_data));

   function automatic logic [31:0] mk(logic [5:0] po, logic [4:0] rt, logic [4:0] ra,
                                      logic [4:0] rb, logic [4:0] rc, logic h, logic [4:0] xo);
      return {po, rt, ra, rb, rc, h, xo};
   endfunction

   function automatic logic [XLEN-1:0] ref2(logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                                            logic [XLEN-1:0] c, logic h);
      logic [3:0] t = h ? c[7:4] : c[3:0];
      logic [XLEN-1:0] r;
      for (int i = 0; i < XLEN; i++) r[i] = t[{a[i], b[i]}];
      return r;
   endfunction

   function automatic logic [XLEN-1:0] tern(logic [XLEN-1:0] t, logic [XLEN-1:0] a,
                                            logic [XLEN-1:0] b, logic [7:0] imm);
      logic [XLEN-1:0] r;
      for (int i = 0; i < XLEN; i++) r[i] = imm[{t[i], a[i], b[i]}];
      return r;
   endfunction

   function automatic logic [XLEN-1:0] lut3(logic [XLEN-1:0] s, logic [XLEN-1:0] a,
                                            logic [XLEN-1:0] b, logic [7:0] tb);
      logic [XLEN-1:0] r;
      for (int i = 0; i < XLEN; i++) r[i] = tb[{s[i], a[i], b[i]}];
      return r;
   endfunction

   task automatic chk(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic present(logic [31:0] ins, logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                          logic [XLEN-1:0] c);
      issue_valid = 1'b1; issue_instr = ins;
      opnd_ra = a; opnd_rb = b; opnd_rc = c;
   endtask

   task automatic idle();
      issue_valid = 1'b0; issue_instr = '0;
      opnd_ra = '0; opnd_rb = '0; opnd_rc = '0;
   endtask

   // one issue; at return the result of it is on the outputs
   task automatic run_one(logic [31:0] ins, logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                          logic [XLEN-1:0] c);
      @(negedge clk);
      present(ins, a, b, c);
      @(negedge clk);
      idle();
   endtask

   task automatic t_reset();
      chk("R1", "valid in reset", {63'd0, res_valid}, 64'd0);
      chk("R1", "wen in reset", {63'd0, res_wen}, 64'd0);
      chk("R1", "data in reset", res_data, 64'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "valid after reset", {63'd0, res_valid}, 64'd0);
      chk("R1", "data after reset", res_data, 64'd0);
   endtask

   task automatic t_decode();
      @(negedge clk);
      present(mk(PO, 5'd3, 5'd17, 5'd9, 5'd30, 1'b0, XO), '0, '0, '0);
      #1;
      chk("R2", "ra idx", {59'd0, src_ra_idx}, 64'd17);
      chk("R2", "rb idx", {59'd0, src_rb_idx}, 64'd9);
      chk("R2", "rc idx", {59'd0, src_rc_idx}, 64'd30);
      @(negedge clk);
      idle();
   endtask

   task automatic t_all_tables();
      logic [XLEN-1:0] a = 64'hCCCC_F0F0_3C3C_A5A5;
      logic [XLEN-1:0] b = 64'hAAAA_FF00_6969_0FF0;
      for (int t = 0; t < 16; t++) begin
         logic [XLEN-1:0] c = {56'hDEAD_BEEF_1234_56, 4'(~t), 4'(t)};
         run_one(mk(PO, 5'd4, 5'd1, 5'd2, 5'd3, 1'b0, XO), a, b, c);
         chk("R3", $sformatf("low table %0d", t), res_data, ref2(a, b, c, 1'b0));
      end
      // R5: single-index tables give one-hot lane patterns
      run_one(mk(PO, 5'd4, 5'd1, 5'd2, 5'd3, 1'b0, XO), 64'hC, 64'hA, 64'h4);
      chk("R5", "index 2 = a&~b", res_data, 64'h4);
      run_one(mk(PO, 5'd4, 5'd1, 5'd2, 5'd3, 1'b0, XO), 64'hC, 64'hA, 64'h2);
      chk("R5", "index 1 = ~a&b", res_data, 64'h2);
   endtask

   task automatic t_high_half();
      logic [XLEN-1:0] a = 64'h0123_4567_89AB_CDEF;
      logic [XLEN-1:0] b = 64'hFEDC_BA98_7654_3210;
      run_one(mk(PO, 5'd5, 5'd1, 5'd2, 5'd3, 1'b1, XO), a, b, 64'h0000_0000_0000_0060);
      chk("R4", "high nibble 6 xor", res_data, a ^ b);
      run_one(mk(PO, 5'd5, 5'd1, 5'd2, 5'd3, 1'b1, XO), a, b, 64'hFFFF_FFFF_FFFF_FF6F);
      chk("R4", "upper rc bits ignored", res_data, a ^ b);
      run_one(mk(PO, 5'd5, 5'd1, 5'd2, 5'd3, 1'b1, XO), a, b, 64'h0000_0000_0000_0081);
      chk("R4", "high nibble 8 and", res_data, a & b);
   endtask

   task automatic t_dest_valid();
      run_one(mk(PO, 5'd27, 5'd1, 5'd2, 5'd3, 1'b0, XO), '1, '0, 64'h4);
      chk("R7", "dest", {59'd0, res_dest}, 64'd27);
      chk("R6", "valid pulse", {63'd0, res_valid}, 64'd1);
      chk("R8", "wen on match", {63'd0, res_wen}, 64'd1);
      @(negedge clk);
      chk("R6", "valid drops", {63'd0, res_valid}, 64'd0);
      chk("R6", "data held", res_data, '1);
      chk("R6", "dest held", {59'd0, res_dest}, 64'd27);
   endtask

   task automatic t_mismatch();
      run_one(mk(PO, 5'd8, 5'd1, 5'd2, 5'd3, 1'b0, 5'd12), '1, '1, 64'h8);
      chk("R8", "ext mismatch valid", {63'd0, res_valid}, 64'd1);
      chk("R8", "ext mismatch wen", {63'd0, res_wen}, 64'd0);
      run_one(mk(6'd23, 5'd8, 5'd1, 5'd2, 5'd3, 1'b0, XO), '1, '1, 64'h8);
      chk("R8", "prim mismatch wen", {63'd0, res_wen}, 64'd0);
   endtask

   task automatic t_back_to_back();
      logic [XLEN-1:0] a = 64'h5555_0000_FFFF_3333;
      logic [XLEN-1:0] b = 64'h0F0F_F0F0_1234_8888;
      @(negedge clk);
      present(mk(PO, 5'd10, 5'd1, 5'd2, 5'd3, 1'b0, XO), a, b, 64'h0000_0000_0000_00E8);
      @(negedge clk);
      chk("R9", "first data", res_data, a & b);
      chk("R9", "first dest", {59'd0, res_dest}, 64'd10);
      chk("R9", "first wen", {63'd0, res_wen}, 64'd1);
      present(mk(PO, 5'd11, 5'd1, 5'd2, 5'd3, 1'b1, 5'd0), a, b, 64'h0000_0000_0000_00E8);
      @(negedge clk);
      idle();
      chk("R9", "second data", res_data, a | b);
      chk("R9", "second dest", {59'd0, res_dest}, 64'd11);
      chk("R9", "second wen", {63'd0, res_wen}, 64'd0);
      chk("R9", "second valid", {63'd0, res_valid}, 64'd1);
   endtask

   task automatic t_chain();
      logic [XLEN-1:0] r4 = 64'h9E37_79B9_7F4A_7C15;
      logic [XLEN-1:0] r5 = 64'hBF58_476D_1CE4_E5B9;
      logic [XLEN-1:0] r6 = 64'h94D0_49BB_1331_11EB;
      logic [XLEN-1:0] x, y, m;
      for (int k = 0; k < 3; k++) begin
         logic [7:0] tb = 8'(8'h96 + k * 8'h35);
         logic [XLEN-1:0] r7 = {56'h1357_9BDF_0246_8A, tb};
         run_one(mk(PO, 5'd3, 5'd4, 5'd5, 5'd7, 1'b0, XO), r4, r5, r7);
         x = res_data;
         run_one(mk(PO, 5'd4, 5'd4, 5'd5, 5'd7, 1'b1, XO), r4, r5, r7);
         y = res_data;
         m = tern(x, y, r6, 8'hD8);
         chk("R10", $sformatf("lut3 chain %0d", k), m, lut3(r6, r4, r5, tb));
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_decode();
      t_all_tables();
      t_high_half();
      t_dest_valid();
      t_mismatch();
      t_back_to_back();
      t_chain();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule